// File: doc/BRIEF.md
# Transmit Sample Packer

This block sits between a 32-bit software write port and the transmit FIFO that feeds a serial audio framer. It can pack several narrow samples into one FIFO word. On the write side, byte-strobed writes are gathered in a staging register. Only a finished 32-bit word is pushed into the FIFO, so the FIFO write pointer moves once per complete word. On the read side, the block takes words from the head of the FIFO and hands the framer one sample per slot request. Each sample comes from the next narrow lane of the current word and is zero-extended to the full width.

A 2-bit mode input selects the packing:
- 2'b00: no packing.
- 2'b10: four 8-bit samples per word.
- 2'b11: two 16-bit samples per word.
- 2'b01: reserved, behaves exactly like 2'b00.

A start-of-frame flag from the framer aligns every frame to a new FIFO word. Any lanes of the previous word that were not consumed are dropped.

The FIFO itself lies outside this block. It is a first-word-fall-through FIFO: its head word and a not-empty flag are inputs, and the block returns a pop strobe in the same cycle.

Top module: `tx_sample_packer`

## Requirements
- R1: While reset is high, and in the first cycle after reset, `push_en`, `sample_valid` and `underrun` are low. The staging register is empty, so after reset four single-byte writes in packed mode produce exactly one push.
- R2: In modes 2'b00 and 2'b01, a write with a nonzero strobe raises `push_en` for one cycle, one cycle after the write. `push_data` carries the strobed bytes of `wr_data`, and bytes without a strobe are zero.
- R3: In modes 2'b10 and 2'b11, strobed bytes collect in the staging register across writes, in any order, and a later write to the same byte replaces it. `push_en` pulses one cycle after the write that completes all four byte lanes. That push carries the merged word, and the staging register then starts empty. Before completion, no push happens.
- R4: A write with an all-zero strobe changes nothing: it causes no push and adds nothing to the staging register.
- R5: In mode 2'b10, consecutive slots of one word return bits 7:0, 15:8, 23:16 and 31:24, in that order, each zero-extended to 32 bits.
- R6: In mode 2'b11, consecutive slots of one word return bits 15:0 and then 31:16, each zero-extended to 32 bits.
- R7: In modes 2'b00 and 2'b01, every slot request pops one FIFO word and returns it whole.
- R8: `pop_en` is asserted in the same cycle as the slot request that takes the first lane of a new FIFO word, and at no other time. After the last lane of a word is used, the next request takes a new word.
- R9: A slot request with `slot_sof` high always starts from lane 0 of a new FIFO word, and it discards any unused lanes of the current word.
- R10: `sample_valid` and `sample_data` are updated one cycle after a slot request.
- R11: If a request needs a new word and `fifo_nonempty` is low, there is no pop and no `sample_valid`, and `underrun` pulses one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Packing select: 00 off, 01 reserved (off), 10 byte, 11 halfword |
| wr_en | input | 1 | Software write strobe |
| wr_strb | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| push_en | output | 1 | FIFO push (write pointer advance) |
| push_data | output | 32 | Completed word for the FIFO |
| fifo_head | input | 32 | Word at the FIFO head |
| fifo_nonempty | input | 1 | FIFO holds at least one word |
| pop_en | output | 1 | FIFO pop (read pointer advance), combinational |
| slot_req | input | 1 | Framer asks for the next sample |
| slot_sof | input | 1 | This request opens a new frame |
| sample_valid | output | 1 | Sample returned for last request |
| sample_data | output | 32 | Zero-extended sample |
| underrun | output | 1 | Last request found the FIFO empty |

## Verification
An error in the write-side lane mask shows up as a push that is missing, early or doubled, one cycle after the write that should or should not complete the word. A wrong lane counter shows up in the first sample after it goes wrong: a sample taken from the wrong byte, or a pop that comes early or never comes. An error in frame alignment shows up at the next request with `slot_sof` high, as a missing pop together with stale sample data. Every such fault therefore reaches the ports within one or two cycles of the request or write that triggers it.

// File: rtl/txpk_pkg.sv
package txpk_pkg;
  typedef enum logic [1:0] {
    PK_OFF  = 2'b00,
    PK_RSVD = 2'b01,
    PK_BYTE = 2'b10,
    PK_HALF = 2'b11
  } pk_mode_e;

  function automatic logic pk_is_packed(input pk_mode_e m);
    return (m == PK_BYTE) || (m == PK_HALF);
  endfunction
endpackage

// File: rtl/txpk_stager.sv
module txpk_stager #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              packed_mode,
  input  logic              wr_en,
  input  logic [DATA_W/8-1:0] wr_strb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              push_en,
  output logic [DATA_W-1:0] push_data
);
  localparam int NB = DATA_W / 8;

  logic [NB-1:0]     acc_mask;
  logic [DATA_W-1:0] acc_data;
  logic [NB-1:0]     merged_mask;
  logic [DATA_W-1:0] merged_data;
  logic [DATA_W-1:0] fresh_data;
  logic              any_strb;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign merged_data[b*8 +: 8] = wr_strb[b] ? wr_data[b*8 +: 8] : acc_data[b*8 +: 8];
    assign fresh_data[b*8 +: 8]  = wr_strb[b] ? wr_data[b*8 +: 8] : 8'h00;
  end

  assign merged_mask = acc_mask | wr_strb;
  assign any_strb    = |wr_strb;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_mask  <= '0;
      acc_data  <= '0;
      push_en   <= 1'b0;
      push_data <= '0;
    end else begin
      push_en <= 1'b0;
      if (wr_en && any_strb) begin
        if (!packed_mode) begin
          push_en   <= 1'b1;
          push_data <= fresh_data;
          acc_mask  <= '0;
          acc_data  <= '0;
        end else if (&merged_mask) begin
          push_en   <= 1'b1;
          push_data <= merged_data;
          acc_mask  <= '0;
          acc_data  <= '0;
        end else begin
          acc_mask <= merged_mask;
          acc_data <= merged_data;
        end
      end
    end
  end
endmodule

// File: rtl/txpk_unpacker.sv
module txpk_unpacker
  import txpk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  pk_mode_e          mode,
  input  logic [DATA_W-1:0] fifo_head,
  input  logic              fifo_nonempty,
  output logic              pop_en,
  input  logic              slot_req,
  input  logic              slot_sof,
  output logic              sample_valid,
  output logic [DATA_W-1:0] sample_data,
  output logic              underrun
);
  localparam int NB = DATA_W / 8;
  localparam int LW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [LW-1:0] LAST_BYTE = LW'(NB - 1);
  localparam logic [LW-1:0] LAST_HALF = LW'(NB / 2 - 1);

  logic [DATA_W-1:0] cur_word;
  logic              cur_valid;
  logic [LW-1:0]     lane_q;

  logic              need_fresh;
  logic [DATA_W-1:0] sel_word;
  logic [LW-1:0]     sel_lane;
  logic [LW-1:0]     last_lane;
  logic [DATA_W-1:0] byte_sh;
  logic [DATA_W-1:0] half_sh;
  logic [DATA_W-1:0] lane_val;

  assign need_fresh = slot_sof || !cur_valid;
  assign pop_en     = slot_req && need_fresh && fifo_nonempty;
  assign sel_word   = need_fresh ? fifo_head : cur_word;
  assign sel_lane   = need_fresh ? '0 : lane_q;

  always_comb begin
    unique case (mode)
      PK_BYTE: last_lane = LAST_BYTE;
      PK_HALF: last_lane = LAST_HALF;
      default: last_lane = '0;
    endcase
  end

  assign byte_sh = sel_word >> {sel_lane, 3'b000};
  assign half_sh = sel_word >> {sel_lane, 4'b0000};

  always_comb begin
    unique case (mode)
      PK_BYTE: lane_val = {{(DATA_W-8){1'b0}},  byte_sh[7:0]};
      PK_HALF: lane_val = {{(DATA_W-16){1'b0}}, half_sh[15:0]};
      default: lane_val = sel_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_word     <= '0;
      cur_valid    <= 1'b0;
      lane_q       <= '0;
      sample_valid <= 1'b0;
      sample_data  <= '0;
      underrun     <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      underrun     <= 1'b0;
      if (slot_req) begin
        if (need_fresh && !fifo_nonempty) begin
          underrun  <= 1'b1;
          cur_valid <= 1'b0;
        end else begin
          sample_valid <= 1'b1;
          sample_data  <= lane_val;
          cur_word     <= sel_word;
          if (sel_lane == last_lane) begin
            cur_valid <= 1'b0;
            lane_q    <= '0;
          end else begin
            cur_valid <= 1'b1;
            lane_q    <= sel_lane + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tx_sample_packer.sv
module tx_sample_packer
  import txpk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              wr_en,
  input  logic [DATA_W/8-1:0] wr_strb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              push_en,
  output logic [DATA_W-1:0] push_data,
  input  logic [DATA_W-1:0] fifo_head,
  input  logic              fifo_nonempty,
  output logic              pop_en,
  input  logic              slot_req,
  input  logic              slot_sof,
  output logic              sample_valid,
  output logic [DATA_W-1:0] sample_data,
  output logic              underrun
);
  pk_mode_e mode_e;
  assign mode_e = pk_mode_e'(mode);

  txpk_stager #(.DATA_W(DATA_W)) stager_i (
    .clk         (clk),
    .rst         (rst),
    .packed_mode (pk_is_packed(mode_e)),
    .wr_en       (wr_en),
    .wr_strb     (wr_strb),
    .wr_data     (wr_data),
    .push_en     (push_en),
    .push_data   (push_data)
  );

  txpk_unpacker #(.DATA_W(DATA_W)) unpacker_i (
    .clk           (clk),
    .rst           (rst),
    .mode          (mode_e),
    .fifo_head     (fifo_head),
    .fifo_nonempty (fifo_nonempty),
    .pop_en        (pop_en),
    .slot_req      (slot_req),
    .slot_sof      (slot_sof),
    .sample_valid  (sample_valid),
    .sample_data   (sample_data),
    .underrun      (underrun)
  );
endmodule

// File: rtl/tx_sample_packer_chk.sv
module tx_sample_packer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic              wr_en,
  input logic [DATA_W/8-1:0] wr_strb,
  input logic              push_en,
  input logic              fifo_nonempty,
  input logic              pop_en,
  input logic              slot_req,
  input logic              slot_sof,
  input logic              sample_valid,
  input logic [DATA_W-1:0] sample_data,
  input logic              underrun
);
  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    pop_en |-> (fifo_nonempty && slot_req)); // R8

  AST_SOF_TAKES_FRESH: assert property (@(posedge clk) disable iff (rst)
    (slot_req && slot_sof && fifo_nonempty) |-> pop_en); // R9

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    (sample_valid || underrun) |-> $past(slot_req)); // R10

  AST_UNDERRUN_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(sample_valid && underrun)); // R11

  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && $past(mode) == 2'b10) |-> (sample_data[DATA_W-1:8] == '0)); // R5

  AST_HALF_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && $past(mode) == 2'b11) |-> (sample_data[DATA_W-1:16] == '0)); // R6

  AST_PUSH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    push_en |-> ($past(wr_en) && $past(|wr_strb))); // R4

  AST_UNPACKED_PUSH: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (|wr_strb) && !mode[1]) |=> push_en); // R2
endmodule

bind tx_sample_packer tx_sample_packer_chk #(.DATA_W(DATA_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .mode          (mode),
  .wr_en         (wr_en),
  .wr_strb       (wr_strb),
  .push_en       (push_en),
  .fifo_nonempty (fifo_nonempty),
  .pop_en        (pop_en),
  .slot_req      (slot_req),
  .slot_sof      (slot_sof),
  .sample_valid  (sample_valid),
  .sample_data   (sample_data),
  .underrun      (underrun)
);

// File: tb/tx_sample_packer_tb_top.sv
`timescale 1ns/1ps
module tx_sample_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_strb = 4'h0;
  logic [31:0] wr_data = '0;
  logic        push_en;
  logic [31:0] push_data;
  logic [31:0] fifo_head;
  logic        fifo_nonempty;
  logic        pop_en;
  logic        slot_req = 1'b0;
  logic        slot_sof = 1'b0;
  logic        sample_valid;
  logic [31:0] sample_data;
  logic        underrun;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] fmem [0:15];
  logic [4:0]  frd = '0;
  logic [4:0]  fwr = '0;
  assign fifo_head     = fmem[frd[3:0]];
  assign fifo_nonempty = (frd != fwr);

  always #2.5 clk = ~clk;

  tx_sample_packer dut_i (
    .clk(clk), .rst(rst), .mode(mode),
    .wr_en(wr_en), .wr_strb(wr_strb), .wr_data(wr_data),
    .push_en(push_en), .push_data(push_data),
    .fifo_head(fifo_head), .fifo_nonempty(fifo_nonempty), .pop_en(pop_en),
    .slot_req(slot_req), .slot_sof(slot_sof),
    .sample_valid(sample_valid), .sample_data(sample_data), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fifo_load(input logic [31:0] w);
    fmem[fwr[3:0]] = w;
    fwr = fwr + 1'b1;
  endtask

  task automatic fifo_flush();
    frd = fwr;
  endtask

  task automatic do_write(input logic [3:0] s, input logic [31:0] d,
                          input bit exp_push, input logic [31:0] exp_data, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_strb = s; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_strb = 4'h0;
    chk(push_en == exp_push, req, {31'b0, push_en}, {31'b0, exp_push});
    if (exp_push) chk(push_data == exp_data, req, push_data, exp_data);
  endtask

  task automatic do_slot(input bit sof, input bit exp_pop, input bit exp_under,
                         input logic [31:0] exp_data, input string req);
    bit p;
    @(negedge clk);
    slot_req = 1'b1; slot_sof = sof;
    #1;
    p = pop_en;
    chk(p == exp_pop, {req, " pop"}, {31'b0, p}, {31'b0, exp_pop});
    @(posedge clk); #1;
    slot_req = 1'b0; slot_sof = 1'b0;
    if (p) frd = frd + 1'b1;
    chk(underrun == exp_under, {req, " underrun"}, {31'b0, underrun}, {31'b0, exp_under});
    chk(sample_valid == !exp_under, {req, " valid"}, {31'b0, sample_valid}, {31'b0, !exp_under});
    if (!exp_under) chk(sample_data == exp_data, {req, " data"}, sample_data, exp_data);
  endtask

  function automatic logic [31:0] mix(input logic [3:0] s, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = s[i] ? b[i*8 +: 8] : a[i*8 +: 8];
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) fmem[i] = '0;
    repeat (3) @(posedge clk); #1;
    chk(!push_en && !sample_valid && !underrun, "R1 in reset", {29'b0, push_en, sample_valid, underrun}, 32'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk(!push_en && !sample_valid && !underrun, "R1 after reset", {29'b0, push_en, sample_valid, underrun}, 32'd0);

    // R1: staging empty after reset: four single bytes give exactly one push
    mode = 2'b10;
    do_write(4'h1, 32'h000000A1, 1'b0, '0, "R1 byte0");
    do_write(4'h2, 32'h0000B200, 1'b0, '0, "R1 byte1");
    do_write(4'h4, 32'h00C30000, 1'b0, '0, "R1 byte2");
    do_write(4'h8, 32'hD4000000, 1'b1, 32'hD4C3B2A1, "R1 byte3");

    // Write sweep: every mode, every strobe mask, then the complement
    for (int md = 0; md < 4; md++) begin
      mode = md[1:0];
      for (int m = 0; m < 16; m++) begin
        logic [31:0] d1, d2;
        logic [3:0]  s, c;
        s  = m[3:0];
        c  = ~s;
        d1 = 32'h11223344 ^ {4{s, 4'h5}};
        d2 = 32'hA0B0C0D0 + {28'd0, s};
        if (md < 2) begin
          do_write(s, d1, (s != 0), mix(s, 32'h0, d1), (md == 0) ? "R2 off" : "R2 reserved");
          do_write(c, d2, (c != 0), mix(c, 32'h0, d2), "R2 complement");
        end else if (s == 4'h0) begin
          do_write(s, d1, 1'b0, '0, "R4 zero strobe");
          do_write(4'hF, d2, 1'b1, d2, "R4 after zero strobe");
        end else if (s == 4'hF) begin
          do_write(s, d1, 1'b1, d1, "R3 full write");
        end else begin
          do_write(s, d1, 1'b0, '0, "R3 partial");
          do_write(c, d2, 1'b1, mix(c, d1, d2), "R3 merge");
        end
      end
    end

    // R3: overwrite of a staged byte
    mode = 2'b11;
    do_write(4'h1, 32'h00000011, 1'b0, '0, "R3 stage");
    do_write(4'h1, 32'h00000022, 1'b0, '0, "R3 overwrite");
    do_write(4'hE, 32'h33445500, 1'b1, 32'h33445522, "R3 overwrite result");

    // R11: underrun on empty FIFO
    fifo_flush();
    mode = 2'b10;
    do_slot(1'b1, 1'b0, 1'b1, '0, "R11 empty sof");
    do_slot(1'b0, 1'b0, 1'b1, '0, "R11 empty no sof");

    // R5/R8: byte mode, three words, frames of four slots
    for (int w = 0; w < 3; w++) fifo_load(32'h01020304 * (w + 1) + 32'h80706050);
    for (int w = 0; w < 3; w++) begin
      logic [31:0] word;
      word = 32'h01020304 * (w + 1) + 32'h80706050;
      for (int l = 0; l < 4; l++)
        do_slot(l == 0, l == 0, 1'b0, (word >> (8 * l)) & 32'hFF, "R5 byte lane");
    end
    do_slot(1'b0, 1'b0, 1'b1, '0, "R11 after drain");

    // R6/R8: halfword mode, no sof after the first slot
    mode = 2'b11;
    fifo_load(32'hBEEF1234);
    fifo_load(32'hCAFE5678);
    do_slot(1'b1, 1'b1, 1'b0, 32'h00001234, "R6 half lo w0");
    do_slot(1'b0, 1'b0, 1'b0, 32'h0000BEEF, "R6 half hi w0");
    do_slot(1'b0, 1'b1, 1'b0, 32'h00005678, "R8 next word");
    do_slot(1'b0, 1'b0, 1'b0, 32'h0000CAFE, "R6 half hi w1");

    // R7: unpacked modes, one word per slot
    for (int md = 0; md < 2; md++) begin
      mode = md[1:0];
      fifo_load(32'h13579BDF + md);
      fifo_load(32'h2468ACE0 + md);
      do_slot(1'b1, 1'b1, 1'b0, 32'h13579BDF + md, "R7 whole word a");
      do_slot(1'b0, 1'b1, 1'b0, 32'h2468ACE0 + md, "R7 whole word b");
    end

    // R9: sof in the middle of a packed word discards the rest
    mode = 2'b10;
    fifo_load(32'hDDCCBBAA);
    fifo_load(32'h44332211);
    do_slot(1'b1, 1'b1, 1'b0, 32'h000000AA, "R9 lane0");
    do_slot(1'b0, 1'b0, 1'b0, 32'h000000BB, "R9 lane1");
    do_slot(1'b1, 1'b1, 1'b0, 32'h00000011, "R9 realign");
    do_slot(1'b0, 1'b0, 1'b0, 32'h00000022, "R9 continue");
    mode = 2'b11;
    fifo_load(32'h9999AAAA);
    do_slot(1'b1, 1'b1, 1'b0, 32'h0000AAAA, "R9 half realign");

    // R10: outputs idle one cycle after the request ends
    @(posedge clk); #1;
    chk(!sample_valid && !underrun, "R10 idle", {30'b0, sample_valid, underrun}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule